// File: doc/BRIEF.md
# Host Bridge Address Window Translator

This block sits between a parent bus and a child PCI-style bus and decides where each transaction goes. It keeps one address window per child address space: memory (index 0), I/O (index 1), configuration (index 2) and special (index 3). Each window holds a parent-side base, a child-side base and a byte size. A load port fills the windows during initialisation. A clear input empties them all.

Parent-side requests arrive on a valid/ready stream. The block finds the first window, in space-index order, that contains the whole request span. It rebases the address into child space and returns the result on a second valid/ready stream one cycle later. Child-side DMA requests go through their own stream. The block checks each one against the bridge's own memory window and either forwards it upward, unchanged, with the memory window's parent-space selector, or rejects it.

A single-cycle attach check tells whether a device behind the bridge may claim a given range with a given decode type. Back-pressure works the same way on both streams. Each stream has a single output register. A request is taken when `*_valid` and `*_ready` are both high, and `*_ready` is high whenever the output register is empty or is being drained in the same cycle. While `*_ready` is low on an output, the result on that output holds steady.

Top module: `phb_window_xlate`

## Requirements
- R1: A `cfg_wr` pulse to a space whose window size is zero stores that space's parent base, child base and size. A load of the memory space (index 0) also stores `cfg_psel`. The new window takes effect from the next cycle.
- R2: A `cfg_wr` to a space whose window size is nonzero leaves the table unchanged and raises `cfg_dup_err` for exactly one cycle, the cycle after the write.
- R3: `win_clear` sets every window size to zero on the next edge, which disables all windows. It takes priority over a `cfg_wr` in the same cycle.
- R4: An `init_chk` pulse drives `init_err` high on the next cycle exactly when every window size is zero.
- R5: A parent request of N bytes at address A hits a window only when the window size is nonzero, A >= parent base, and A+N <= parent base + size. The sums are computed with 33 bits, so they never wrap.
- R6: When several windows hit, the one with the lowest space index wins.
- R7: On a hit, `res_addr` = A − parent base + child base, taken modulo 2^32, and `res_space` gives the space index. The encoding is 0 memory, 1 I/O, 2 configuration, 3 special.
- R8: A request that hits no window returns `res_hit`=0, `res_space`=0 and `res_addr`=0, and it is not forwarded to the child side.
- R9: Each accepted request produces its result on the next cycle, with `res_len` equal to the request length. While a result is held back by a low `res_ready`, it stays stable and `up_ready` stays low.
- R10: A DMA request whose `dma_space` is not 0 (memory) returns `dres_err_space`=1 and is not forwarded.
- R11: A memory-space DMA is rejected with `dres_err_overlap`=1 when its start A or its end A+N lies in the inclusive range from child base to child base + size of the memory window.
- R12: Any other memory-space DMA returns `dres_fwd`=1. In that case `dres_addr` = A, `dres_len` = N, and `dres_psel` is the selector stored with the memory window. Exactly one of the three DMA outcome flags is set on each result.
- R13: An `att_chk` pulse drives `att_bad` high on the next cycle when either of two things holds. The first is that `att_decode` is neither 0 (normal) nor 1 (subtractive); codes 2 and 3 are invalid. The second is that the span from `att_addr` to `att_addr`+`att_len` does not fit inside the child range of window `att_space`; a window of size zero fits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_clear | input | 1 | Zero all window sizes |
| cfg_wr | input | 1 | Load one window |
| cfg_space | input | 2 | Space index to load |
| cfg_pbase | input | 32 | Parent-side base |
| cfg_cbase | input | 32 | Child-side base |
| cfg_size | input | 32 | Window size in bytes |
| cfg_psel | input | 2 | Parent-space selector, kept for the memory window |
| cfg_dup_err | output | 1 | Duplicate-load flag |
| init_chk | input | 1 | Request an empty-table check |
| init_err | output | 1 | Table was empty at the check |
| up_valid | input | 1 | Parent request valid |
| up_ready | output | 1 | Parent request accepted |
| up_addr | input | 32 | Parent request address |
| up_len | input | LEN_W | Parent request byte count |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | A window claimed the request |
| res_space | output | 2 | Space index of the hit |
| res_addr | output | 32 | Child-side address |
| res_len | output | LEN_W | Byte count carried through |
| dma_valid | input | 1 | DMA request valid |
| dma_ready | output | 1 | DMA request accepted |
| dma_space | input | 2 | Space named by the DMA |
| dma_addr | input | 32 | DMA address |
| dma_len | input | LEN_W | DMA byte count |
| dres_valid | output | 1 | DMA result valid |
| dres_ready | input | 1 | DMA result consumer ready |
| dres_fwd | output | 1 | DMA forwarded upward |
| dres_err_space | output | 1 | DMA named a non-memory space |
| dres_err_overlap | output | 1 | DMA touches the bridge's own memory window |
| dres_psel | output | 2 | Parent-space selector for the forwarded DMA |
| dres_addr | output | 32 | Forwarded DMA address |
| dres_len | output | LEN_W | Forwarded DMA byte count |
| att_chk | input | 1 | Request an attach check |
| att_space | input | 2 | Space of the attach |
| att_addr | input | 32 | Child-side attach address |
| att_len | input | LEN_W | Attach span in bytes |
| att_decode | input | 2 | Decode type, 0 normal, 1 subtractive |
| att_bad | output | 1 | Attach rejected |

## Verification
The bench builds the block with its defaults: 32-bit addresses and an 8-bit length. With these, request spans can straddle a window edge by a few bytes, and a window placed just below 2^32 lets A+N reach 2^32 exactly or pass it by one. That exposes any sum that wraps at 32 bits. The four fixed spaces let overlapping windows test the index priority. The DMA cases place the start or the end exactly on both edges of the memory window's child range.

// File: rtl/phb_xlate_pkg.sv
package phb_xlate_pkg;
  localparam int AW  = 32;
  localparam int NSP = 4;
  localparam int SPW = $clog2(NSP);
  localparam int PSW = 2;

  typedef enum logic [SPW-1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2,
    SP_SPC = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    DEC_NORMAL = 2'd0,
    DEC_SUBTR  = 2'd1,
    DEC_ABORT  = 2'd2,
    DEC_RSVD   = 2'd3
  } decode_e;

  // span [a, a+n) lies inside [base, base+size); widened by one bit
  function automatic logic span_fits(input logic [AW-1:0] base,
                                     input logic [AW-1:0] size,
                                     input logic [AW-1:0] a,
                                     input logic [AW:0]   n);
    logic [AW:0] lo, hi, s, e;
    lo = {1'b0, base};
    hi = lo + {1'b0, size};
    s  = {1'b0, a};
    e  = s + n;
    return (size != '0) && (s >= lo) && (e <= hi);
  endfunction
endpackage

// File: rtl/phb_win_table.sv
module phb_win_table
  import phb_xlate_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_clear,
  input  logic                    cfg_wr,
  input  logic [SPW-1:0]          cfg_space,
  input  logic [AW-1:0]           cfg_pbase,
  input  logic [AW-1:0]           cfg_cbase,
  input  logic [AW-1:0]           cfg_size,
  input  logic [PSW-1:0]          cfg_psel,
  input  logic                    init_chk,
  output logic [NSP-1:0][AW-1:0]  pb,
  output logic [NSP-1:0][AW-1:0]  cb,
  output logic [NSP-1:0][AW-1:0]  sz,
  output logic [PSW-1:0]          mem_psel,
  output logic                    dup_err,
  output logic                    init_err
);
  logic [NSP-1:0] live;

  for (genvar g = 0; g < NSP; g++) begin : g_live
    assign live[g] = |sz[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb       <= '0;
      cb       <= '0;
      sz       <= '0;
      mem_psel <= '0;
      dup_err  <= 1'b0;
      init_err <= 1'b0;
    end else begin
      dup_err  <= 1'b0;
      init_err <= init_chk && !(|live);
      if (win_clear) begin
        sz <= '0;
      end else if (cfg_wr) begin
        if (live[cfg_space]) begin
          dup_err <= 1'b1;
        end else begin
          pb[cfg_space] <= cfg_pbase;
          cb[cfg_space] <= cfg_cbase;
          sz[cfg_space] <= cfg_size;
          if (cfg_space == SP_MEM) mem_psel <= cfg_psel;
        end
      end
    end
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    win_clear |=> (sz == '0)); // R3
  AST_DUP_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !win_clear && live[cfg_space]) |=> ($stable(pb) && $stable(cb) && $stable(sz) && dup_err)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !win_clear && !live[cfg_space]) |=>
      (pb[$past(cfg_space)] == $past(cfg_pbase) && sz[$past(cfg_space)] == $past(cfg_size))); // R1
endmodule

// File: rtl/phb_fwd_xlate.sv
module phb_fwd_xlate
  import phb_xlate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSP-1:0][AW-1:0]  pb,
  input  logic [NSP-1:0][AW-1:0]  cb,
  input  logic [NSP-1:0][AW-1:0]  sz,
  input  logic                    up_valid,
  output logic                    up_ready,
  input  logic [AW-1:0]           up_addr,
  input  logic [LEN_W-1:0]        up_len,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic                    res_hit,
  output logic [SPW-1:0]          res_space,
  output logic [AW-1:0]           res_addr,
  output logic [LEN_W-1:0]        res_len
);
  localparam int PAD = AW + 1 - LEN_W;

  logic [AW:0]     n_ext;
  logic [NSP-1:0]  hitv;
  logic            sel_hit;
  logic [SPW-1:0]  sel_sp;
  logic [AW-1:0]   xaddr;

  assign n_ext = {{PAD{1'b0}}, up_len};

  for (genvar g = 0; g < NSP; g++) begin : g_win
    assign hitv[g] = span_fits(pb[g], sz[g], up_addr, n_ext);
  end

  always_comb begin
    sel_hit = |hitv;
    sel_sp  = '0;
    for (int i = NSP - 1; i >= 0; i--) begin
      if (hitv[i]) sel_sp = SPW'(i);
    end
  end

  assign xaddr    = sel_hit ? (up_addr - pb[sel_sp] + cb[sel_sp]) : '0;
  assign up_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_space <= '0;
      res_addr  <= '0;
      res_len   <= '0;
    end else if (up_valid && up_ready) begin
      res_valid <= 1'b1;
      res_hit   <= sel_hit;
      res_space <= sel_sp;
      res_addr  <= xaddr;
      res_len   <= up_len;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_space) && $stable(res_hit))); // R9
  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (res_valid && res_len == $past(up_len))); // R9
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_addr == '0 && res_space == '0)); // R8
endmodule

// File: rtl/phb_dma_gate.sv
module phb_dma_gate
  import phb_xlate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      mem_cb,
  input  logic [AW-1:0]      mem_sz,
  input  logic [PSW-1:0]     mem_psel,
  input  logic               dma_valid,
  output logic               dma_ready,
  input  logic [SPW-1:0]     dma_space,
  input  logic [AW-1:0]      dma_addr,
  input  logic [LEN_W-1:0]   dma_len,
  output logic               dres_valid,
  input  logic               dres_ready,
  output logic               dres_fwd,
  output logic               dres_err_space,
  output logic               dres_err_overlap,
  output logic [PSW-1:0]     dres_psel,
  output logic [AW-1:0]      dres_addr,
  output logic [LEN_W-1:0]   dres_len
);
  localparam int PAD = AW + 1 - LEN_W;

  logic [AW:0] s, e, lo, hi;
  logic        bad_sp, ovl;

  assign s      = {1'b0, dma_addr};
  assign e      = s + {{PAD{1'b0}}, dma_len};
  assign lo     = {1'b0, mem_cb};
  assign hi     = lo + {1'b0, mem_sz};
  assign bad_sp = (dma_space != SP_MEM);
  assign ovl    = ((s >= lo) && (s <= hi)) || ((e >= lo) && (e <= hi));

  assign dma_ready = !dres_valid || dres_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dres_valid       <= 1'b0;
      dres_fwd         <= 1'b0;
      dres_err_space   <= 1'b0;
      dres_err_overlap <= 1'b0;
      dres_psel        <= '0;
      dres_addr        <= '0;
      dres_len         <= '0;
    end else if (dma_valid && dma_ready) begin
      dres_valid       <= 1'b1;
      dres_err_space   <= bad_sp;
      dres_err_overlap <= !bad_sp && ovl;
      dres_fwd         <= !bad_sp && !ovl;
      dres_psel        <= mem_psel;
      dres_addr        <= dma_addr;
      dres_len         <= dma_len;
    end else if (dres_ready) begin
      dres_valid <= 1'b0;
    end
  end

  AST_DMA_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    dres_valid |-> ($countones({dres_fwd, dres_err_space, dres_err_overlap}) == 1)); // R12
  AST_DMA_SPACE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready && dma_space != SP_MEM) |=> (dres_err_space && !dres_fwd)); // R10
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dres_valid && !dres_ready) |=> (dres_valid && $stable(dres_addr) && $stable(dres_fwd))); // R12
endmodule

// File: rtl/phb_window_xlate.sv
module phb_window_xlate
  import phb_xlate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_clear,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_space,
  input  logic [31:0]        cfg_pbase,
  input  logic [31:0]        cfg_cbase,
  input  logic [31:0]        cfg_size,
  input  logic [1:0]         cfg_psel,
  output logic               cfg_dup_err,
  input  logic               init_chk,
  output logic               init_err,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [31:0]        up_addr,
  input  logic [LEN_W-1:0]   up_len,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic [1:0]         res_space,
  output logic [31:0]        res_addr,
  output logic [LEN_W-1:0]   res_len,
  input  logic               dma_valid,
  output logic               dma_ready,
  input  logic [1:0]         dma_space,
  input  logic [31:0]        dma_addr,
  input  logic [LEN_W-1:0]   dma_len,
  output logic               dres_valid,
  input  logic               dres_ready,
  output logic               dres_fwd,
  output logic               dres_err_space,
  output logic               dres_err_overlap,
  output logic [1:0]         dres_psel,
  output logic [31:0]        dres_addr,
  output logic [LEN_W-1:0]   dres_len,
  input  logic               att_chk,
  input  logic [1:0]         att_space,
  input  logic [31:0]        att_addr,
  input  logic [LEN_W-1:0]   att_len,
  input  logic [1:0]         att_decode,
  output logic               att_bad
);
  localparam int PAD = AW + 1 - LEN_W;

  logic [NSP-1:0][AW-1:0] pb, cb, sz;
  logic [PSW-1:0]         mem_psel;
  logic                   att_dec_ok, att_fit;

  phb_win_table u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_clear (win_clear),
    .cfg_wr    (cfg_wr),
    .cfg_space (cfg_space),
    .cfg_pbase (cfg_pbase),
    .cfg_cbase (cfg_cbase),
    .cfg_size  (cfg_size),
    .cfg_psel  (cfg_psel),
    .init_chk  (init_chk),
    .pb        (pb),
    .cb        (cb),
    .sz        (sz),
    .mem_psel  (mem_psel),
    .dup_err   (cfg_dup_err),
    .init_err  (init_err)
  );

  phb_fwd_xlate #(.LEN_W(LEN_W)) u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pb        (pb),
    .cb        (cb),
    .sz        (sz),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .up_addr   (up_addr),
    .up_len    (up_len),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_hit   (res_hit),
    .res_space (res_space),
    .res_addr  (res_addr),
    .res_len   (res_len)
  );

  phb_dma_gate #(.LEN_W(LEN_W)) u_dma (
    .clk              (clk),
    .rst_n            (rst_n),
    .mem_cb           (cb[SP_MEM]),
    .mem_sz           (sz[SP_MEM]),
    .mem_psel         (mem_psel),
    .dma_valid        (dma_valid),
    .dma_ready        (dma_ready),
    .dma_space        (dma_space),
    .dma_addr         (dma_addr),
    .dma_len          (dma_len),
    .dres_valid       (dres_valid),
    .dres_ready       (dres_ready),
    .dres_fwd         (dres_fwd),
    .dres_err_space   (dres_err_space),
    .dres_err_overlap (dres_err_overlap),
    .dres_psel        (dres_psel),
    .dres_addr        (dres_addr),
    .dres_len         (dres_len)
  );

  assign att_dec_ok = (att_decode == DEC_NORMAL) || (att_decode == DEC_SUBTR);
  assign att_fit    = span_fits(cb[att_space], sz[att_space], att_addr, {{PAD{1'b0}}, att_len});

  always_ff @(posedge clk) begin
    if (!rst_n) att_bad <= 1'b0;
    else        att_bad <= att_chk && !(att_dec_ok && att_fit);
  end

  AST_ATT_BAD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (att_chk && (att_decode == DEC_ABORT || att_decode == DEC_RSVD)) |=> att_bad); // R13
  AST_ATT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !att_chk |=> !att_bad); // R13
endmodule

// File: tb/phb_window_xlate_tb.sv
module phb_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_clear = 0, cfg_wr = 0, init_chk = 0;
  logic [1:0]  cfg_space = 0, cfg_psel = 0;
  logic [31:0] cfg_pbase = 0, cfg_cbase = 0, cfg_size = 0;
  logic        cfg_dup_err, init_err;
  logic        up_valid = 0, up_ready, res_valid, res_ready = 1, res_hit;
  logic [31:0] up_addr = 0, res_addr;
  logic [7:0]  up_len = 0, res_len;
  logic [1:0]  res_space;
  logic        dma_valid = 0, dma_ready, dres_valid, dres_ready = 1;
  logic        dres_fwd, dres_err_space, dres_err_overlap;
  logic [1:0]  dma_space = 0, dres_psel;
  logic [31:0] dma_addr = 0, dres_addr;
  logic [7:0]  dma_len = 0, dres_len;
  logic        att_chk = 0, att_bad;
  logic [1:0]  att_space = 0, att_decode = 0;
  logic [31:0] att_addr = 0;
  logic [7:0]  att_len = 0;

  int nchk = 0, nerr = 0;
  bit done = 0;
  longint unsigned m_pb[4], m_cb[4], m_sz[4];
  logic [1:0] m_ps;

  always #5 clk = ~clk;

  phb_window_xlate dut_i (.*);

  task automatic chk(input string req, input string what, input longint unsigned act, input longint unsigned exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit fits(input longint unsigned base, input longint unsigned size,
                              input longint unsigned a, input longint unsigned n);
    return (size != 0) && (a >= base) && (a + n <= base + size);
  endfunction

  task automatic load(input int sp, input longint unsigned pbv, input longint unsigned cbv,
                      input longint unsigned szv, input logic [1:0] ps);
    bit dup;
    dup = (m_sz[sp] != 0);
    @(negedge clk);
    cfg_wr = 1; cfg_space = 2'(sp); cfg_pbase = 32'(pbv); cfg_cbase = 32'(cbv);
    cfg_size = 32'(szv); cfg_psel = ps;
    @(negedge clk);
    cfg_wr = 0;
    chk(dup ? "R2" : "R1", "cfg_dup_err", cfg_dup_err, dup);
    if (!dup) begin
      m_pb[sp] = pbv; m_cb[sp] = cbv; m_sz[sp] = szv;
      if (sp == 0) m_ps = ps;
    end
  endtask

  task automatic do_clear(input bool_with_wr);
    @(negedge clk);
    win_clear = 1; cfg_wr = bool_with_wr; cfg_space = 0; cfg_size = 32'h100;
    @(negedge clk);
    win_clear = 0; cfg_wr = 0;
    for (int i = 0; i < 4; i++) m_sz[i] = 0;
  endtask

  task automatic do_init(input string req);
    bit e;
    e = (m_sz[0] == 0) && (m_sz[1] == 0) && (m_sz[2] == 0) && (m_sz[3] == 0);
    @(negedge clk); init_chk = 1;
    @(negedge clk); init_chk = 0;
    chk(req, "init_err", init_err, e);
  endtask

  task automatic do_fwd(input longint unsigned a, input int n, input string req);
    bit h; int s; logic [31:0] x;
    h = 0; s = 0; x = 0;
    for (int i = 3; i >= 0; i--) begin
      if (fits(m_pb[i], m_sz[i], a, longint'(n))) begin
        h = 1; s = i; x = 32'(a - m_pb[i] + m_cb[i]);
      end
    end
    @(negedge clk); up_valid = 1; up_addr = 32'(a); up_len = 8'(n);
    @(negedge clk); up_valid = 0;
    chk("R9", "res_valid", res_valid, 1);
    chk(req, "res_hit", res_hit, h);
    chk(req, "res_space", res_space, s);
    chk(req, "res_addr", res_addr, x);
    chk("R9", "res_len", res_len, n);
  endtask

  task automatic do_dma(input int sp, input longint unsigned a, input int n, input string req);
    bit es, eo, f; longint unsigned lo, hi, e;
    lo = m_cb[0]; hi = m_cb[0] + m_sz[0]; e = a + n;
    es = (sp != 0);
    eo = !es && ((a >= lo && a <= hi) || (e >= lo && e <= hi));
    f  = !es && !eo;
    @(negedge clk); dma_valid = 1; dma_space = 2'(sp); dma_addr = 32'(a); dma_len = 8'(n);
    @(negedge clk); dma_valid = 0;
    chk(req, "dres_valid", dres_valid, 1);
    chk("R10", "dres_err_space", dres_err_space, es);
    chk("R11", "dres_err_overlap", dres_err_overlap, eo);
    chk("R12", "dres_fwd", dres_fwd, f);
    if (f) begin
      chk("R12", "dres_addr", dres_addr, a);
      chk("R12", "dres_psel", dres_psel, m_ps);
      chk("R12", "dres_len", dres_len, n);
    end
  endtask

  task automatic do_att(input int sp, input longint unsigned a, input int n, input int dec);
    bit bad;
    bad = (dec > 1) || !fits(m_cb[sp], m_sz[sp], a, longint'(n));
    @(negedge clk); att_chk = 1; att_space = 2'(sp); att_addr = 32'(a); att_len = 8'(n);
    att_decode = 2'(dec);
    @(negedge clk); att_chk = 0;
    chk("R13", "att_bad", att_bad, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    for (int i = 0; i < 4; i++) begin m_pb[i] = 0; m_cb[i] = 0; m_sz[i] = 0; end
    m_ps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "reset res_valid", res_valid, 0);
    chk("R9", "reset up_ready", up_ready, 1);
    chk("R12", "reset dres_valid", dres_valid, 0);
    chk("R13", "reset att_bad", att_bad, 0);

    do_init("R4");
    do_fwd(64'h8000_0000, 4, "R8");

    load(0, 64'h8000_0000, 64'h8000_0000, 64'h1000_0000, 2'd1);
    load(1, 64'hC000_0000, 64'h0, 64'h1_0000, 2'd2);
    do_init("R4");
    load(0, 64'h1000, 64'h2000, 64'h10, 2'd3);      // duplicate, R2
    do_fwd(64'h8000_1234, 4, "R2");
    do_fwd(64'h8FFF_FFFC, 4, "R5");
    do_fwd(64'h8FFF_FFFC, 5, "R5");
    do_fwd(64'h7FFF_FFFF, 2, "R5");
    do_fwd(64'hC000_0010, 4, "R7");
    load(2, 64'h8000_0000, 64'h100, 64'h100, 2'd0);
    do_fwd(64'h8000_0010, 4, "R6");
    load(3, 64'hC000_0000, 64'h4000, 64'h100, 2'd0);
    do_fwd(64'hC000_0020, 8, "R6");
    do_fwd(64'hD000_0000, 1, "R8");

    // back-pressure, R9
    @(negedge clk); res_ready = 0; up_valid = 1; up_addr = 32'hC000_0040; up_len = 8'd4;
    @(negedge clk);
    chk("R9", "held res_valid", res_valid, 1);
    chk("R9", "held up_ready", up_ready, 0);
    up_addr = 32'hC000_0080;
    repeat (2) @(negedge clk);
    chk("R9", "held res_addr", res_addr, 32'h40);
    res_ready = 1;
    @(negedge clk); up_valid = 0;
    chk("R9", "next res_addr", res_addr, 32'h80);

    do_dma(1, 64'h1000, 4, "R10");
    do_dma(0, 64'h8000_1000, 4, "R11");
    do_dma(0, 64'h7FFF_FFFC, 4, "R11");
    do_dma(0, 64'h9000_0000, 4, "R11");
    do_dma(0, 64'h7FFF_FFF0, 4, "R12");
    do_dma(0, 64'h9000_0001, 4, "R12");

    do_att(1, 64'h100, 4, 2);
    do_att(1, 64'h100, 4, 0);
    do_att(1, 64'hFFFC, 4, 1);
    do_att(1, 64'hFFFD, 4, 1);

    do_clear(1);                                      // R3 with concurrent load
    do_init("R3");
    do_fwd(64'h8000_1234, 4, "R3");

    load(3, 64'hFFFF_FF00, 64'h0, 64'h100, 2'd0);
    do_fwd(64'hFFFF_FFFC, 4, "R5");
    do_fwd(64'hFFFF_FFFC, 5, "R5");

    for (int it = 0; it < 40; it++) begin
      do_clear(0);
      for (int k = 0; k < 5; k++) begin
        longint unsigned pbv, szv;
        pbv = 64'h8000_0000 + (longint'($urandom_range(0, 3)) << 28) + (longint'($urandom) & 64'h00FF_0000);
        szv = ($urandom_range(0, 7) == 0) ? 0 : longint'($urandom_range(1, 32'h0100_0000));
        load(int'($urandom_range(0, 3)), pbv, longint'($urandom), szv, 2'($urandom));
      end
      do_init("R4");
      for (int k = 0; k < 8; k++) begin
        int w; longint unsigned a;
        w = int'($urandom_range(0, 3));
        a = (m_pb[w] + ($urandom % (m_sz[w] + 64)) - 32) & 64'hFFFF_FFFF;
        do_fwd(a, int'($urandom_range(0, 255)), "R7");
        a = (m_cb[0] + ($urandom % (m_sz[0] + 64)) - 32) & 64'hFFFF_FFFF;
        do_dma(($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 3)) : 0, a,
               int'($urandom_range(0, 255)), "R11");
        a = (m_cb[w] + ($urandom % (m_sz[w] + 64)) - 32) & 64'hFFFF_FFFF;
        do_att(w, a, int'($urandom_range(0, 255)), int'($urandom_range(0, 3)));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule